// File: doc/BRIEF.md
# Over-Current Protection Controller

This block is the digital protection core of a three-leg half-bridge gate driver. It sits between the six gate commands coming from a motor controller and the six gate outputs going to the drivers. It watches a digital over-current flag from an external comparator, a supply under-voltage flag and an enable input. A fault from either flag is latched. While latched, an active-low fault output is driven low and every gate output is forced off.

The fault releases only after the fault condition has disappeared and a clear timer has run its full length. The timer stands in for the external capacitor that sets the clear delay, and it starts over whenever a condition comes back. Switching spikes right after a low-side switch turns on are masked by a leading-edge blanking window on the over-current flag. Enable is a separate, non-latching shutdown path. It passes through a glitch filter and never raises the fault output.

Top module: `pcg_prot_ctrl`

## Requirements
- R1: When not faulted, if `oc_flag` is high at a clock edge outside the blanking window, `fault_n` is low from that edge on and all gate outputs are 0 from that same edge.
- R2: `uv_flag` high at any clock edge sets the fault at that edge, even inside the blanking window.
- R3: While `fault_n` is low, every bit of `hi_gate` and `lo_gate` is 0.
- R4: Once faulted, `fault_n` returns high at the `CLR_CYC`-th consecutive edge at which both `oc_flag` (unblanked) and `uv_flag` are low. Any edge with either flag high restarts that count.
- R5: A low-side rise is an edge at which some bit of `lo_cmd` is 1 and was 0 at the previous edge. `oc_flag` is ignored at a rise edge and at the following `BLANK_CYC` edges. Every new rise restarts the window.
- R6: A change of `en_in` takes effect only after it has held for `EN_FLT_CYC` consecutive edges. Shorter pulses leave the gate outputs unchanged.
- R7: The gate outputs are 0 from the edge after the filtered enable goes low. Enable shutdown does not drive `fault_n` low.
- R8: When not faulted and the filtered enable is high, each gate output equals its command as sampled at the previous edge.
- R9: In reset and after reset, `fault_n` is low and all gates are 0. The fault releases at the `CLR_CYC`-th clean edge after reset, and the filtered enable starts low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_flag | input | 1 | Over-current comparator flag, high on over-current |
| uv_flag | input | 1 | Supply under-voltage flag, high when supply is low |
| en_in | input | 1 | Raw enable, high to allow switching |
| hi_cmd | input | N_LEG | High-side gate commands, one bit per leg |
| lo_cmd | input | N_LEG | Low-side gate commands, one bit per leg |
| hi_gate | output | N_LEG | High-side gate outputs |
| lo_gate | output | N_LEG | Low-side gate outputs |
| fault_n | output | 1 | Active-low latched fault indication |

## Verification
The bench targets the exact edges where the blanking window ends. A window that is off by one would trip one edge early, or miss a real over-current one edge late. It also brings back a condition one edge before the clear count would finish. A timer that does not reload on that edge would release the fault with the fault still present. Under-voltage is raised inside an active blanking window, where a design that masks the whole fault path would keep driving the gates. Enable pulses one edge shorter than the filter length must not reach the gates, and a filtered enable-low must shut the gates without raising the fault output.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    // Width of a counter that must hold values 0..limit
    function automatic int cnt_bits(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/pcg_en_filter.sv
module pcg_en_filter #(
    parameter int FLT_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    output logic en_flt
);
    localparam int CW = pcg_pkg::cnt_bits(FLT_CYC);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_st_t;

    flt_st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (en_in != s_q.lvl) begin
            if (s_q.cnt == CW'(FLT_CYC - 1)) begin
                s_d.lvl = en_in;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_flt = s_q.lvl;

    // R6: the filtered level only ever moves toward the sampled raw input
    a_r6_flip_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.lvl != $past(s_q.lvl)) |-> ($past(en_in) == s_q.lvl));

    // R6: a matching raw input keeps the filtered level still
    a_r6_match_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en_in == en_flt) |=> $stable(en_flt));

endmodule

// File: rtl/pcg_blanker.sv
module pcg_blanker #(
    parameter int N_LEG     = 3,
    parameter int BLANK_CYC = 130
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LEG-1:0] lo_cmd,
    input  logic             oc_raw,
    output logic             blank,
    output logic             oc_valid
);
    localparam int BW = pcg_pkg::cnt_bits(BLANK_CYC);

    typedef struct packed {
        logic [N_LEG-1:0] prev;
        logic [BW-1:0]    cnt;
    } blk_st_t;

    blk_st_t s_q, s_d;
    logic    rise;

    always_comb begin
        rise     = |(lo_cmd & ~s_q.prev);
        blank    = rise || (s_q.cnt != '0);
        oc_valid = oc_raw && !blank;
        s_d      = s_q;
        s_d.prev = lo_cmd;
        if (rise)                s_d.cnt = BW'(BLANK_CYC);
        else if (s_q.cnt != '0)  s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5: window counts down one per edge unless a new rise reloads it
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != '0 && !rise) |=> (s_q.cnt == $past(s_q.cnt) - 1'b1));

    // R5: a rise always leaves the window open on the next edge
    a_r5_rise_opens: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (s_q.cnt != '0));

endmodule

// File: rtl/pcg_fault_timer.sv
module pcg_fault_timer #(
    parameter int CLR_CYC = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic hold_req,
    output logic fault_q,
    output logic fault_nxt
);
    localparam int CW = pcg_pkg::cnt_bits(CLR_CYC);

    typedef struct packed {
        logic          fault;
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (!s_q.fault) begin
            if (set_req) begin
                s_d.fault = 1'b1;
                s_d.cnt   = CW'(CLR_CYC);
            end
        end else if (hold_req) begin
            s_d.cnt = CW'(CLR_CYC);
        end else if (s_q.cnt <= CW'(1)) begin
            s_d.fault = 1'b0;
            s_d.cnt   = '0;
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        fault_nxt = s_d.fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.fault <= 1'b1;
            s_q.cnt   <= CW'(CLR_CYC);
        end else begin
            s_q <= s_d;
        end
    end

    assign fault_q = s_q.fault;

    // R1: a valid request latches the fault
    a_r1_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_q && set_req) |=> fault_q);

    // R4: a present condition never lets the fault go
    a_r4_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && hold_req) |=> fault_q);

    // R4: release happens only on a quiet edge
    a_r4_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_q) |-> !$past(hold_req));

endmodule

// File: rtl/pcg_prot_ctrl.sv
module pcg_prot_ctrl #(
    parameter int N_LEG      = 3,
    parameter int BLANK_CYC  = 130,
    parameter int CLR_CYC    = 300000,
    parameter int EN_FLT_CYC = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oc_flag,
    input  logic             uv_flag,
    input  logic             en_in,
    input  logic [N_LEG-1:0] hi_cmd,
    input  logic [N_LEG-1:0] lo_cmd,
    output logic [N_LEG-1:0] hi_gate,
    output logic [N_LEG-1:0] lo_gate,
    output logic             fault_n
);
    typedef struct packed {
        logic [N_LEG-1:0] hi;
        logic [N_LEG-1:0] lo;
    } gate_st_t;

    gate_st_t g_q, g_d;
    logic     en_flt;
    logic     blank;
    logic     oc_valid;
    logic     fault_q;
    logic     fault_nxt;
    logic     set_req;
    logic     hold_req;
    logic     drive_ok;

    pcg_en_filter #(.FLT_CYC(EN_FLT_CYC)) u_en_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_in  (en_in),
        .en_flt (en_flt)
    );

    pcg_blanker #(.N_LEG(N_LEG), .BLANK_CYC(BLANK_CYC)) u_blanker (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_cmd   (lo_cmd),
        .oc_raw   (oc_flag),
        .blank    (blank),
        .oc_valid (oc_valid)
    );

    pcg_fault_timer #(.CLR_CYC(CLR_CYC)) u_fault_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req   (set_req),
        .hold_req  (hold_req),
        .fault_q   (fault_q),
        .fault_nxt (fault_nxt)
    );

    always_comb begin
        set_req  = oc_valid || uv_flag;
        hold_req = oc_flag  || uv_flag;
        drive_ok = en_flt && !fault_nxt;
        g_d.hi   = hi_cmd & {N_LEG{drive_ok}};
        g_d.lo   = lo_cmd & {N_LEG{drive_ok}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign hi_gate = g_q.hi;
    assign lo_gate = g_q.lo;
    assign fault_n = !fault_q;

    // R3: no gate may be on while the fault is reported
    a_r3_gates_off_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (hi_gate == '0 && lo_gate == '0));

    // R7: filtered enable low turns every gate off on the next edge
    a_r7_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_flt |=> (hi_gate == '0 && lo_gate == '0));

    // R2: under-voltage reports a fault on the next edge
    a_r2_uv_trips: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> !fault_n);

    // R5: inside the window, over-current alone cannot trip
    a_r5_blank_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_n && blank && !uv_flag) |=> fault_n);

endmodule

// File: tb/tb_pcg_prot_ctrl.sv
`timescale 1ns/1ps
module tb_pcg_prot_ctrl;
    localparam int NL = 3;
    localparam int BC = 8;
    localparam int CC = 20;
    localparam int FC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          oc_flag = 1'b0, uv_flag = 1'b0, en_in = 1'b1;
    logic [NL-1:0] hi_cmd = '0, lo_cmd = '0;
    logic [NL-1:0] hi_gate, lo_gate;
    logic          fault_n;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pcg_prot_ctrl #(.N_LEG(NL), .BLANK_CYC(BC), .CLR_CYC(CC), .EN_FLT_CYC(FC)) dut (
        .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .uv_flag(uv_flag), .en_in(en_in),
        .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .hi_gate(hi_gate), .lo_gate(lo_gate),
        .fault_n(fault_n)
    );

    // Reference model built from the requirements
    logic [NL-1:0] m_prev, m_hi, m_lo;
    int            m_blank, m_cnt, m_ecnt;
    bit            m_fault, m_en;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_prev = '0; m_blank = 0; m_fault = 1'b1; m_cnt = CC;
            m_en = 1'b0; m_ecnt = 0; m_hi = '0; m_lo = '0;
        end else begin
            bit rise, blanked, set_c, hold_c, ok;
            rise    = |(lo_cmd & ~m_prev);
            blanked = rise || (m_blank != 0);
            m_prev  = lo_cmd;
            if (rise) m_blank = BC; else if (m_blank != 0) m_blank--;
            set_c  = (oc_flag && !blanked) || uv_flag;
            hold_c = oc_flag || uv_flag;
            if (!m_fault) begin
                if (set_c) begin m_fault = 1'b1; m_cnt = CC; end
            end else if (hold_c) m_cnt = CC;
            else if (m_cnt <= 1) begin m_fault = 1'b0; m_cnt = 0; end
            else m_cnt--;
            ok   = m_en && !m_fault;
            m_hi = ok ? hi_cmd : '0;
            m_lo = ok ? lo_cmd : '0;
            if (en_in != m_en) begin
                if (m_ecnt == FC - 1) begin m_en = en_in; m_ecnt = 0; end
                else m_ecnt++;
            end else m_ecnt = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #750000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(3);
        chk("R9 fault_n in reset", fault_n, 0);
        chk("R9 gates in reset", {hi_gate, lo_gate}, 0);
        rst_n = 1'b1;
        step(CC - 1);
        chk("R9 fault held after reset", fault_n, 0);
        step(1);
        chk("R9 fault released", fault_n, 1);

        hi_cmd = 3'b101; lo_cmd = 3'b010;
        step(1);
        chk("R8 hi follows cmd", hi_gate, 3'b101);
        chk("R8 lo follows cmd", lo_gate, 3'b010);

        oc_flag = 1'b1;
        step(BC);
        chk("R5 oc blanked", fault_n, 1);
        chk("R5 gates still on", lo_gate, 3'b010);
        step(1);
        chk("R1 oc trips after window", fault_n, 0);
        chk("R3 gates off in fault", {hi_gate, lo_gate}, 0);

        step(4);
        oc_flag = 1'b0;
        step(CC - 1);
        chk("R4 not yet cleared", fault_n, 0);
        uv_flag = 1'b1;
        step(1);
        uv_flag = 1'b0;
        step(CC - 1);
        chk("R4 restart holds fault", fault_n, 0);
        step(1);
        chk("R4 clears after full count", fault_n, 1);
        chk("R8 gates resume", {hi_gate, lo_gate}, {3'b101, 3'b010});

        lo_cmd = 3'b000;
        step(1);
        lo_cmd = 3'b010; uv_flag = 1'b1;
        step(1);
        chk("R2 uv trips inside window", fault_n, 0);
        uv_flag = 1'b0;
        step(CC);
        chk("R2 uv fault clears", fault_n, 1);

        en_in = 1'b0;
        step(FC - 1);
        en_in = 1'b1;
        step(6);
        chk("R6 short enable pulse ignored", {hi_gate, lo_gate}, {3'b101, 3'b010});

        en_in = 1'b0;
        step(FC);
        chk("R7 gates on before filtered drop", hi_gate, 3'b101);
        step(1);
        chk("R7 gates off on enable low", {hi_gate, lo_gate}, 0);
        chk("R7 no fault from enable", fault_n, 1);
        en_in = 1'b1;
        step(FC + 1);
        chk("R7 gates back on", hi_gate, 3'b101);

        void'($urandom(32'd4242));
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 8) == 0) begin
                hi_cmd = NL'($urandom);
                lo_cmd = NL'($urandom);
            end
            oc_flag = (($urandom % 12) == 0);
            uv_flag = (($urandom % 90) == 0);
            if (($urandom % 25) == 0) en_in = ~en_in;
            if (i % 500 == 7) begin
                en_in = ~en_in;
                step(FC - 1);
                en_in = ~en_in;
            end
            step(1);
            chk("R4 fault_n vs model", fault_n, m_fault ? 0 : 1);
            chk("R8 hi_gate vs model", hi_gate, m_hi);
            chk("R8 lo_gate vs model", lo_gate, m_lo);
        end
        finish_run();
    end
endmodule